// File: doc/BRIEF.md
# Hardwired Multi-Cycle Accumulator Control Unit

This block is the sequencer of a small 8-bit accumulator core with separate program and data memories and 16-bit instructions. It walks every instruction through a fetch state and a decode state, then through a short execute sequence chosen by the instruction's group. While it does so it drives the datapath controls: the ALU operation, the ALU's drive onto the shared data bus, the ALU second-operand select, the data-RAM address select, program-counter load and increment, the write enables of the accumulator, memory data register, instruction register and flag register, and the active-low data-RAM read and write strobes.

Instructions are sorted into five groups (literal, accumulator-only, register-operand, store and jump), and the control values of a state depend only on the state and the group. A small opcode decoder produces the group, the jump condition, the ALU operation and the operand select; the next-state logic branches only out of the decode state, to one of seven successors. The state register runs on the falling clock edge, so every control is settled half a cycle before the rising edge on which the datapath registers capture. All pins are plain control and status signals; there is no streamed data and so no valid/ready handshake or back-pressure.

Top module: `acc_ctl_top`

## Requirements
- R1: While `rst_n` is low the state is fetch and every write enable, `pc_load`, `pc_inc` and `alu_oe` are 0 with `ram_rd_n` and `ram_wr_n` at 1; the first state after release is fetch.
- R2: Fetch asserts only `ir_we`; it is always followed by decode, which asserts only `pc_inc`, and only for non-jump groups.
- R3: Instruction layout: opcode in bits 15:11, destination bit D in bit 10, extension in bits 9:8, register address or literal in bits 7:0. Opcodes: literal group 0x01 load, 0x02 add, 0x03 subtract, 0x04 and, 0x05 or, 0x06 xor; register group 0x08..0x0D with the same operations in the same order; store 0x10; accumulator group 0x11 complement, 0x12 increment, 0x13 decrement, 0x14 rotate left through carry, 0x15 rotate right through carry; jumps 0x18 always, 0x19 if Z, 0x1A if not Z, 0x1B if C, 0x1C if not C; every other code is undefined.
- R4: Literal and accumulator instructions take one execute state asserting `alu_oe`, `a_we` and `flg_we`, then return to fetch; D has no effect on them.
- R5: A register-operand instruction with D = 0 takes a read state (`ram_rd_n` low, `ram_asel`, `mdr_we`) and then an execute state asserting `alu_oe`, `a_we` and `flg_we`.
- R6: A register-operand instruction with D = 1 takes the read state and then the write tail; a store goes to the write tail directly. The tail is three states (setup, strobe, hold) all asserting `alu_oe` and `ram_asel`; `ram_wr_n` is low only in the strobe state and `flg_we` is asserted only in the hold state.
- R7: A jump whose condition holds takes a state asserting only `pc_load`; otherwise, and for undefined codes, it takes a state asserting only `pc_inc`. `pc_load` and `pc_inc` are never both 1.
- R8: `alu_oe` and a low `ram_rd_n` never occur in the same state.
- R9: `alu_op` codes: 0 pass A, 1 pass operand, 2 and, 3 or, 4 xor, 5 add, 6 subtract, 7 increment, 8 decrement, 9 complement, 10 rotate left, 11 rotate right. Loads use 1, store uses 0, jumps and undefined codes use 0. `alu_bsel` is 1 (memory data register) only for the register group, else 0 (literal).
- R10: The state changes only on falling clock edges, so a datapath clocked on rising edges and enabled by these controls executes a program correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state on falling edge, datapath on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 5 | Opcode field of the instruction register |
| dst_sel | input | 1 | Destination bit D of the instruction register |
| flag_z | input | 1 | Zero flag from the flag register |
| flag_c | input | 1 | Carry flag from the flag register |
| alu_op | output | 4 | ALU operation code |
| alu_bsel | output | 1 | ALU second operand: 1 memory data register, 0 literal |
| alu_oe | output | 1 | ALU drives the shared data bus |
| ram_asel | output | 1 | Data-RAM address from the instruction field |
| ram_rd_n | output | 1 | Data-RAM read strobe, active low |
| ram_wr_n | output | 1 | Data-RAM write strobe, active low, level-sensitive |
| pc_load | output | 1 | Load program counter with the jump target |
| pc_inc | output | 1 | Increment program counter |
| a_we | output | 1 | Accumulator write enable |
| mdr_we | output | 1 | Memory data register write enable |
| ir_we | output | 1 | Instruction register write enable |
| flg_we | output | 1 | Flag register write enable |

## Verification
The assertions take for granted that the opcode, D and the flags change only on rising edges, as they do when they come from datapath registers, so the decode state sees settled values at the falling edge that leaves it. The directed stimulus changes these inputs just after a falling edge that enters fetch and holds them for the whole instruction, and the program run takes them from a rising-edge datapath model. Reset is asserted and released only away from clock edges.

// File: rtl/acc_ctl_pkg.sv
package acc_ctl_pkg;

  localparam int ALU_OP_W = 4;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_LIT_EX, ST_ACC_EX, ST_RDA_RD, ST_RDA_EX,
    ST_RDW_RD, ST_WR_SET, ST_WR_PULSE, ST_WR_HOLD, ST_JMP_LD, ST_JMP_SKIP
  } ctl_state_e;

  typedef enum logic [2:0] {
    GRP_LIT, GRP_ACC, GRP_REG, GRP_STORE, GRP_JUMP
  } op_group_e;

  typedef enum logic [2:0] {
    CND_ALWAYS, CND_Z, CND_NZ, CND_C, CND_NC, CND_NEVER
  } jcond_e;

  typedef enum logic [ALU_OP_W-1:0] {
    ALU_PASS_A = 4'd0, ALU_PASS_B = 4'd1, ALU_AND = 4'd2, ALU_OR = 4'd3,
    ALU_XOR = 4'd4, ALU_ADD = 4'd5, ALU_SUB = 4'd6, ALU_INC = 4'd7,
    ALU_DEC = 4'd8, ALU_NOT = 4'd9, ALU_ROL = 4'd10, ALU_ROR = 4'd11
  } alu_op_e;

  typedef struct packed {
    op_group_e grp;
    jcond_e    cond;
    alu_op_e   op;
    logic      bsel;
  } dec_s;

  typedef struct packed {
    logic alu_oe;
    logic ram_asel;
    logic pc_load;
    logic pc_inc;
    logic a_we;
    logic mdr_we;
    logic ir_we;
    logic flg_we;
    logic ram_rd_n;
    logic ram_wr_n;
  } ctl_s;

  localparam ctl_s CTL_IDLE = '{default: 1'b0, ram_rd_n: 1'b1, ram_wr_n: 1'b1};

  // opcode table (R3)
  localparam logic [4:0] OP_LDI = 5'h01, OP_ADI = 5'h02, OP_SBI = 5'h03,
                         OP_ANI = 5'h04, OP_ORI = 5'h05, OP_XRI = 5'h06;
  localparam logic [4:0] OP_LDR = 5'h08, OP_ADR = 5'h09, OP_SBR = 5'h0A,
                         OP_ANR = 5'h0B, OP_ORR = 5'h0C, OP_XRR = 5'h0D;
  localparam logic [4:0] OP_STA = 5'h10;
  localparam logic [4:0] OP_CPL = 5'h11, OP_INC = 5'h12, OP_DEC = 5'h13,
                         OP_RLC = 5'h14, OP_RRC = 5'h15;
  localparam logic [4:0] OP_JMP = 5'h18, OP_JZ = 5'h19, OP_JNZ = 5'h1A,
                         OP_JC = 5'h1B, OP_JNC = 5'h1C;

endpackage

// File: rtl/acc_ctl_opdec.sv
// Instruction-level decode: group, jump condition, ALU op, operand select.
module acc_ctl_opdec
  import acc_ctl_pkg::*;
#(
  parameter int OPC_W = 5
) (
  input  logic [OPC_W-1:0] opcode,
  output dec_s             dec
);

  function automatic dec_s mk(op_group_e g, jcond_e c, alu_op_e o);
    dec_s d;
    d.grp  = g;
    d.cond = c;
    d.op   = o;
    d.bsel = (g == GRP_REG);
    return d;
  endfunction

  always_comb begin
    case (opcode)
      OP_LDI:  dec = mk(GRP_LIT,   CND_NEVER,  ALU_PASS_B);
      OP_ADI:  dec = mk(GRP_LIT,   CND_NEVER,  ALU_ADD);
      OP_SBI:  dec = mk(GRP_LIT,   CND_NEVER,  ALU_SUB);
      OP_ANI:  dec = mk(GRP_LIT,   CND_NEVER,  ALU_AND);
      OP_ORI:  dec = mk(GRP_LIT,   CND_NEVER,  ALU_OR);
      OP_XRI:  dec = mk(GRP_LIT,   CND_NEVER,  ALU_XOR);
      OP_LDR:  dec = mk(GRP_REG,   CND_NEVER,  ALU_PASS_B);
      OP_ADR:  dec = mk(GRP_REG,   CND_NEVER,  ALU_ADD);
      OP_SBR:  dec = mk(GRP_REG,   CND_NEVER,  ALU_SUB);
      OP_ANR:  dec = mk(GRP_REG,   CND_NEVER,  ALU_AND);
      OP_ORR:  dec = mk(GRP_REG,   CND_NEVER,  ALU_OR);
      OP_XRR:  dec = mk(GRP_REG,   CND_NEVER,  ALU_XOR);
      OP_STA:  dec = mk(GRP_STORE, CND_NEVER,  ALU_PASS_A);
      OP_CPL:  dec = mk(GRP_ACC,   CND_NEVER,  ALU_NOT);
      OP_INC:  dec = mk(GRP_ACC,   CND_NEVER,  ALU_INC);
      OP_DEC:  dec = mk(GRP_ACC,   CND_NEVER,  ALU_DEC);
      OP_RLC:  dec = mk(GRP_ACC,   CND_NEVER,  ALU_ROL);
      OP_RRC:  dec = mk(GRP_ACC,   CND_NEVER,  ALU_ROR);
      OP_JMP:  dec = mk(GRP_JUMP,  CND_ALWAYS, ALU_PASS_A);
      OP_JZ:   dec = mk(GRP_JUMP,  CND_Z,      ALU_PASS_A);
      OP_JNZ:  dec = mk(GRP_JUMP,  CND_NZ,     ALU_PASS_A);
      OP_JC:   dec = mk(GRP_JUMP,  CND_C,      ALU_PASS_A);
      OP_JNC:  dec = mk(GRP_JUMP,  CND_NC,     ALU_PASS_A);
      // undefined codes act as a jump that is never taken (R7)
      default: dec = mk(GRP_JUMP,  CND_NEVER,  ALU_PASS_A);
    endcase
  end

endmodule

// File: rtl/acc_ctl_next.sv
// Next-state logic: sequential everywhere except out of decode.
module acc_ctl_next
  import acc_ctl_pkg::*;
(
  input  ctl_state_e state,
  input  op_group_e  grp,
  input  jcond_e     cond,
  input  logic       dst_sel,
  input  logic       flag_z,
  input  logic       flag_c,
  output ctl_state_e state_d
);

  logic take;

  always_comb begin
    case (cond)
      CND_ALWAYS: take = 1'b1;
      CND_Z:      take = flag_z;
      CND_NZ:     take = !flag_z;
      CND_C:      take = flag_c;
      CND_NC:     take = !flag_c;
      default:    take = 1'b0;
    endcase
  end

  always_comb begin
    case (state)
      ST_FETCH:    state_d = ST_DECODE;
      ST_DECODE: begin
        case (grp)
          GRP_LIT:   state_d = ST_LIT_EX;
          GRP_ACC:   state_d = ST_ACC_EX;
          GRP_REG:   state_d = dst_sel ? ST_RDW_RD : ST_RDA_RD;
          GRP_STORE: state_d = ST_WR_SET;
          default:   state_d = take ? ST_JMP_LD : ST_JMP_SKIP;
        endcase
      end
      ST_RDA_RD:   state_d = ST_RDA_EX;
      ST_RDW_RD:   state_d = ST_WR_SET;
      ST_WR_SET:   state_d = ST_WR_PULSE;
      ST_WR_PULSE: state_d = ST_WR_HOLD;
      default:     state_d = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/acc_ctl_outs.sv
// Control values per state; only decode looks at the group.
module acc_ctl_outs
  import acc_ctl_pkg::*;
(
  input  ctl_state_e state,
  input  op_group_e  grp,
  output ctl_s       ctl
);

  always_comb begin
    ctl = CTL_IDLE;
    case (state)
      ST_FETCH:  ctl.ir_we  = 1'b1;
      ST_DECODE: ctl.pc_inc = (grp != GRP_JUMP);
      ST_LIT_EX, ST_ACC_EX, ST_RDA_EX: begin
        ctl.alu_oe = 1'b1;
        ctl.a_we   = 1'b1;
        ctl.flg_we = 1'b1;
      end
      ST_RDA_RD, ST_RDW_RD: begin
        ctl.ram_asel = 1'b1;
        ctl.ram_rd_n = 1'b0;
        ctl.mdr_we   = 1'b1;
      end
      ST_WR_SET: begin
        ctl.alu_oe   = 1'b1;
        ctl.ram_asel = 1'b1;
      end
      ST_WR_PULSE: begin
        ctl.alu_oe   = 1'b1;
        ctl.ram_asel = 1'b1;
        ctl.ram_wr_n = 1'b0;
      end
      ST_WR_HOLD: begin
        ctl.alu_oe   = 1'b1;
        ctl.ram_asel = 1'b1;
        ctl.flg_we   = 1'b1;
      end
      ST_JMP_LD:   ctl.pc_load = 1'b1;
      ST_JMP_SKIP: ctl.pc_inc  = 1'b1;
      default:     ctl = CTL_IDLE;
    endcase
  end

endmodule

// File: rtl/acc_ctl_top.sv
module acc_ctl_top
  import acc_ctl_pkg::*;
#(
  parameter int OPC_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OPC_W-1:0]    opcode,
  input  logic                dst_sel,
  input  logic                flag_z,
  input  logic                flag_c,
  output logic [ALU_OP_W-1:0] alu_op,
  output logic                alu_bsel,
  output logic                alu_oe,
  output logic                ram_asel,
  output logic                ram_rd_n,
  output logic                ram_wr_n,
  output logic                pc_load,
  output logic                pc_inc,
  output logic                a_we,
  output logic                mdr_we,
  output logic                ir_we,
  output logic                flg_we
);

  dec_s       dec;
  ctl_state_e state_q, state_d;
  ctl_s       ctl_raw, ctl_o;

  acc_ctl_opdec #(.OPC_W(OPC_W)) u_opdec (
    .opcode (opcode),
    .dec    (dec)
  );

  acc_ctl_next u_next (
    .state   (state_q),
    .grp     (dec.grp),
    .cond    (dec.cond),
    .dst_sel (dst_sel),
    .flag_z  (flag_z),
    .flag_c  (flag_c),
    .state_d (state_d)
  );

  acc_ctl_outs u_outs (
    .state (state_q),
    .grp   (dec.grp),
    .ctl   (ctl_raw)
  );

  // state register on the falling edge; datapath captures on the rising edge (R10)
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end

  // reset holds every control inactive (R1)
  assign ctl_o    = rst_n ? ctl_raw : CTL_IDLE;
  assign alu_op   = dec.op;
  assign alu_bsel = dec.bsel;
  assign alu_oe   = ctl_o.alu_oe;
  assign ram_asel = ctl_o.ram_asel;
  assign ram_rd_n = ctl_o.ram_rd_n;
  assign ram_wr_n = ctl_o.ram_wr_n;
  assign pc_load  = ctl_o.pc_load;
  assign pc_inc   = ctl_o.pc_inc;
  assign a_we     = ctl_o.a_we;
  assign mdr_we   = ctl_o.mdr_we;
  assign ir_we    = ctl_o.ir_we;
  assign flg_we   = ctl_o.flg_we;

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (!a_we && !mdr_we && !ir_we && !flg_we && !pc_load &&
                                    !pc_inc && !alu_oe && ram_rd_n && ram_wr_n)
        else $error("controls active during reset");
    end
  end

  assert_fetch_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH) |=> (state_q == ST_DECODE))
    else $error("fetch not followed by decode");

  assert_strobe_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_wr_n) |-> $past(alu_oe && ram_asel && ram_wr_n))
    else $error("write strobe without setup state");

  assert_strobe_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_wr_n) |-> (alu_oe && ram_asel))
    else $error("write strobe without hold state");

  assert_pc_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pc_load && pc_inc))
    else $error("pc load and increment together");

  assert_pcload_after_decode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> ($past(state_q) == ST_DECODE))
    else $error("pc load not directly after decode");

  assert_bus_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(alu_oe && !ram_rd_n))
    else $error("ALU and RAM both drive the bus");

endmodule

// File: tb/tb_acc_ctl_top.sv
module tb_acc_ctl_top;

  // control vector bit order: alu_oe ram_asel pc_load pc_inc a_we mdr_we ir_we flg_we ram_rd_n ram_wr_n
  localparam logic [9:0] V_IDLE   = 10'b0000000011;
  localparam logic [9:0] V_FETCH  = 10'b0000001011;
  localparam logic [9:0] V_DECI   = 10'b0001000011;
  localparam logic [9:0] V_DECN   = 10'b0000000011;
  localparam logic [9:0] V_EXEC   = 10'b1000100111;
  localparam logic [9:0] V_RD     = 10'b0100010001;
  localparam logic [9:0] V_WSET   = 10'b1100000011;
  localparam logic [9:0] V_WPUL   = 10'b1100000010;
  localparam logic [9:0] V_WHOLD  = 10'b1100000111;
  localparam logic [9:0] V_JMP    = 10'b0010000011;
  localparam logic [9:0] V_SKIP   = 10'b0001000011;

  localparam int G_LIT = 0, G_ACC = 1, G_REG = 2, G_STO = 3, G_JMP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       prog_mode = 1'b0;
  logic [4:0] drv_opc = 5'h0;
  logic       drv_d = 1'b0, drv_z = 1'b0, drv_c = 1'b0;

  logic [15:0] dp_ir;
  logic [9:0]  dp_pc;
  logic [7:0]  dp_a, dp_mdr;
  logic        dp_z, dp_c;
  logic [15:0] prog [0:15];
  logic [7:0]  ram  [0:255];

  logic [3:0] alu_op;
  logic alu_bsel, alu_oe, ram_asel, ram_rd_n, ram_wr_n, pc_load, pc_inc;
  logic a_we, mdr_we, ir_we, flg_we;

  acc_ctl_top dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .opcode   (prog_mode ? dp_ir[15:11] : drv_opc),
    .dst_sel  (prog_mode ? dp_ir[10] : drv_d),
    .flag_z   (prog_mode ? dp_z : drv_z),
    .flag_c   (prog_mode ? dp_c : drv_c),
    .alu_op   (alu_op),
    .alu_bsel (alu_bsel),
    .alu_oe   (alu_oe),
    .ram_asel (ram_asel),
    .ram_rd_n (ram_rd_n),
    .ram_wr_n (ram_wr_n),
    .pc_load  (pc_load),
    .pc_inc   (pc_inc),
    .a_we     (a_we),
    .mdr_we   (mdr_we),
    .ir_we    (ir_we),
    .flg_we   (flg_we)
  );

  logic [9:0] obs;
  assign obs = {alu_oe, ram_asel, pc_load, pc_inc, a_we, mdr_we, ir_we, flg_we, ram_rd_n, ram_wr_n};

  int tests_run = 0;
  int tests_failed = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- specification tables (R3, R9) ----------------
  function automatic int grp_of(input logic [4:0] o);
    if (o >= 5'h01 && o <= 5'h06) return G_LIT;
    if (o >= 5'h08 && o <= 5'h0D) return G_REG;
    if (o == 5'h10)               return G_STO;
    if (o >= 5'h11 && o <= 5'h15) return G_ACC;
    return G_JMP;
  endfunction

  function automatic logic [3:0] op_of(input logic [4:0] o);
    case (o)
      5'h01, 5'h08: return 4'd1;
      5'h02, 5'h09: return 4'd5;
      5'h03, 5'h0A: return 4'd6;
      5'h04, 5'h0B: return 4'd2;
      5'h05, 5'h0C: return 4'd3;
      5'h06, 5'h0D: return 4'd4;
      5'h11: return 4'd9;
      5'h12: return 4'd7;
      5'h13: return 4'd8;
      5'h14: return 4'd10;
      5'h15: return 4'd11;
      default: return 4'd0;
    endcase
  endfunction

  function automatic bit taken_of(input logic [4:0] o, input logic z, input logic c);
    case (o)
      5'h18: return 1'b1;
      5'h19: return z;
      5'h1A: return !z;
      5'h1B: return c;
      5'h1C: return !c;
      default: return 1'b0;
    endcase
  endfunction

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [9:0] v;
    logic [3:0] op;
    logic       bsel;
    bit         chk_op;
    string      tag;
  } exp_t;
  exp_t q[$];

  // driver: pushes the expected per-state controls, then holds the instruction
  task automatic run_insn(input logic [4:0] opc, input logic d, input logic z,
                          input logic c, input string tag);
    logic [9:0] seq [6];
    int n;
    int g;
    exp_t e;
    g = grp_of(opc);
    seq[0] = V_FETCH;
    n = 3;
    case (g)
      G_LIT, G_ACC: begin seq[1] = V_DECI; seq[2] = V_EXEC; n = 3; end
      G_REG: begin
        seq[1] = V_DECI; seq[2] = V_RD;
        if (!d) begin seq[3] = V_EXEC; n = 4; end
        else begin seq[3] = V_WSET; seq[4] = V_WPUL; seq[5] = V_WHOLD; n = 6; end
      end
      G_STO: begin seq[1] = V_DECI; seq[2] = V_WSET; seq[3] = V_WPUL; seq[4] = V_WHOLD; n = 5; end
      default: begin seq[1] = V_DECN; seq[2] = taken_of(opc, z, c) ? V_JMP : V_SKIP; n = 3; end
    endcase
    drv_opc = opc; drv_d = d; drv_z = z; drv_c = c;
    for (int i = 0; i < n; i++) begin
      e.v = seq[i]; e.op = op_of(opc); e.bsel = (g == G_REG);
      e.chk_op = (i > 0); e.tag = tag;
      q.push_back(e);
    end
    repeat (n) @(negedge clk);
    #1;
  endtask

  // monitor: samples mid-way between a falling edge and the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(obs == e.v, e.tag, "controls", {22'd0, obs}, {22'd0, e.v});
        if (e.chk_op) begin
          check(alu_op == e.op, e.tag, "alu_op", {28'd0, alu_op}, {28'd0, e.op});
          check(alu_bsel == e.bsel, e.tag, "alu_bsel", {31'd0, alu_bsel}, {31'd0, e.bsel});
        end
      end
    end
  end

  // ---------------- datapath model for the program run (R10) ----------------
  function automatic logic [8:0] alu_f(input logic [3:0] op, input logic [7:0] a,
                                       input logic [7:0] b, input logic cin);
    case (op)
      4'd0:  return {cin, a};
      4'd1:  return {cin, b};
      4'd2:  return {cin, a & b};
      4'd3:  return {cin, a | b};
      4'd4:  return {cin, a ^ b};
      4'd5:  return {1'b0, a} + {1'b0, b};
      4'd6:  return {1'b0, a} - {1'b0, b};
      4'd7:  return {cin, a + 8'd1};
      4'd8:  return {cin, a - 8'd1};
      4'd9:  return {cin, ~a};
      4'd10: return {a[7], a[6:0], cin};
      4'd11: return {a[0], cin, a[7:1]};
      default: return {cin, a};
    endcase
  endfunction

  logic [8:0] alu_r;
  assign alu_r = alu_f(alu_op, dp_a, alu_bsel ? dp_mdr : dp_ir[7:0], dp_c);

  always @(posedge clk) begin
    if (!rst_n) begin
      dp_ir <= 16'h0; dp_pc <= 10'h0; dp_a <= 8'h0; dp_mdr <= 8'h0;
      dp_z <= 1'b0; dp_c <= 1'b0;
      for (int i = 0; i < 256; i++) ram[i] <= 8'h0;
      ram[20] <= 8'd200; ram[21] <= 8'd100; ram[22] <= 8'd7;
      ram[23] <= 8'd1;   ram[24] <= 8'd3;   ram[41] <= 8'd9;
    end else if (prog_mode) begin
      if (ir_we) dp_ir <= prog[dp_pc[3:0]];
      if (pc_load) dp_pc <= dp_ir[9:0];
      else if (pc_inc) dp_pc <= dp_pc + 10'd1;
      if (mdr_we && !ram_rd_n) dp_mdr <= ram[ram_asel ? dp_ir[7:0] : dp_a];
      if (a_we && alu_oe) dp_a <= alu_r[7:0];
      if (flg_we) begin
        dp_z <= (alu_r[7:0] == 8'h0);
        dp_c <= alu_r[8];
      end
      if (!ram_wr_n && alu_oe) ram[ram_asel ? dp_ir[7:0] : dp_a] <= alu_r[7:0];
    end
  end

  function automatic logic [15:0] enc(input logic [4:0] o, input logic d, input logic [7:0] f);
    return {o, d, 2'b00, f};
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (50000) @(posedge clk);
    tests_run++;
    tests_failed++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [7:0] exp_sum;
    prog[0]  = enc(5'h01, 1'b0, 8'd0);   // load literal 0
    prog[1]  = enc(5'h09, 1'b0, 8'd20);  // add r20
    prog[2]  = enc(5'h09, 1'b0, 8'd21);
    prog[3]  = enc(5'h09, 1'b0, 8'd22);
    prog[4]  = enc(5'h09, 1'b0, 8'd23);
    prog[5]  = enc(5'h09, 1'b0, 8'd24);
    prog[6]  = enc(5'h10, 1'b0, 8'd40);  // store A to r40
    prog[7]  = enc(5'h09, 1'b1, 8'd41);  // r41 = A + r41
    prog[8]  = enc(5'h01, 1'b0, 8'd3);
    prog[9]  = enc(5'h10, 1'b0, 8'd30);
    prog[10] = enc(5'h08, 1'b0, 8'd30);  // A = r30
    prog[11] = enc(5'h13, 1'b0, 8'd0);   // decrement A
    prog[12] = enc(5'h10, 1'b0, 8'd30);
    prog[13] = enc(5'h1A, 1'b0, 8'd10);  // jump if not zero
    prog[14] = enc(5'h18, 1'b0, 8'd14);  // park
    prog[15] = 16'h0;

    // R1: reset state, sampled away from edges
    repeat (3) @(posedge clk);
    #1;
    check(obs == V_IDLE, "R1", "controls in reset", {22'd0, obs}, {22'd0, V_IDLE});
    @(negedge clk);
    #1;
    rst_n = 1'b1;

    // directed instructions, expected controls per state
    run_insn(5'h01, 1'b0, 1'b0, 1'b0, "R1");  // first state after reset is fetch
    run_insn(5'h02, 1'b1, 1'b0, 1'b0, "R4");  // literal add, D ignored
    run_insn(5'h06, 1'b0, 1'b0, 1'b0, "R4");
    run_insn(5'h11, 1'b0, 1'b0, 1'b0, "R4");  // complement
    run_insn(5'h14, 1'b0, 1'b0, 1'b1, "R9");  // rotate left
    run_insn(5'h15, 1'b0, 1'b0, 1'b1, "R9");  // rotate right
    run_insn(5'h09, 1'b0, 1'b0, 1'b0, "R5");  // register add to A
    run_insn(5'h0C, 1'b0, 1'b0, 1'b0, "R8");  // read state, no ALU drive
    run_insn(5'h0A, 1'b1, 1'b0, 1'b0, "R6");  // register subtract to register
    run_insn(5'h10, 1'b0, 1'b0, 1'b0, "R6");  // store
    run_insn(5'h18, 1'b0, 1'b0, 1'b0, "R7");  // unconditional
    run_insn(5'h19, 1'b0, 1'b1, 1'b0, "R7");  // Z set, taken
    run_insn(5'h19, 1'b0, 1'b0, 1'b0, "R7");  // Z clear, not taken
    run_insn(5'h1A, 1'b0, 1'b0, 1'b1, "R7");  // not Z, taken
    run_insn(5'h1B, 1'b0, 1'b0, 1'b1, "R7");  // C set, taken
    run_insn(5'h1C, 1'b0, 1'b0, 1'b1, "R7");  // not C with C set, not taken
    run_insn(5'h00, 1'b1, 1'b1, 1'b1, "R7");  // undefined code skips
    run_insn(5'h1F, 1'b0, 1'b0, 1'b0, "R7");
    run_insn(5'h0F, 1'b1, 1'b0, 1'b0, "R2");  // decode without increment
    while (q.size() > 0) @(negedge clk);
    #1;

    // program run through a datapath model (R10)
    rst_n = 1'b0;
    prog_mode = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1;
    rst_n = 1'b1;
    for (int k = 0; k < 2000 && dp_pc != 10'd14; k++) @(posedge clk);
    repeat (12) @(posedge clk);
    #1;

    exp_sum = 8'd200 + 8'd100 + 8'd7 + 8'd1 + 8'd3;
    check(dp_pc == 10'd14, "R10", "program parked", {22'd0, dp_pc}, 32'd14);
    check(ram[40] == exp_sum, "R10", "stored sum", {24'd0, ram[40]}, {24'd0, exp_sum});
    check(ram[41] == exp_sum + 8'd9, "R6", "register destination", {24'd0, ram[41]},
          {24'd0, exp_sum + 8'd9});
    check(ram[30] == 8'd0, "R10", "loop counter", {24'd0, ram[30]}, 32'd0);
    check(dp_a == 8'd0, "R10", "accumulator", {24'd0, dp_a}, 32'd0);
    check(dp_z == 1'b1, "R7", "loop exit flag", {31'd0, dp_z}, 32'd1);

    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule